// File: doc/BRIEF.md
# Interrupt Remap Control Registers

This block is the register slice that holds the programming state of an interrupt-remapping unit. Software stages a 64-bit table address register. That register carries the table base in its upper bits and a size code in its low nibble. Software may write it as two 32-bit halves or as one 64-bit access. A write to the global command register then copies the staged value into live state. The same command register also switches remapping on or off. The matching status bits can be read back from a global status register.

The live table base, the number of table entries and the remapping enable are exported to the interrupt translator. The translator does not have to decode any register. A read-only extended capability register reports that interrupt remapping is available. The bus has a write strobe, a read strobe, a byte offset, a one-bit size select (0 = 4 bytes, 1 = 8 bytes) and 64-bit data in both directions. Read data is combinational and is zero when no read is active.

Register offsets used below: extended capability 0x010, global command 0x018, global status 0x01C, table address low half 0x0B8, table address high half 0x0BC. A 4-byte read returns its 32-bit value in bits 31:0 of the read data.

Top module: `irq_remap_regs`

## Requirements
- R1: After reset, tbl_base is 0, tbl_entries is 0, remap_en is 0, global status (0x01C) reads 0 and the table address register reads 0.
- R2: In the table address register only bits 63:12 and 3:0 can be written. A write mask of 0xFFFFFFFFFFFFF00F applies, and bits 11:4 always read as zero.
- R3: After a pointer latch, tbl_entries equals 2 shifted left by the latched size code S (bits 3:0), giving 2^(S+1). The range runs from 2 for S=0 up to 65536 for S=15.
- R4: After a pointer latch, tbl_base equals the staged address with bits 11:0 cleared, truncated to HAW bits. The default HAW is 48.
- R5: Every command write with bit 24 set latches base and size and sets status bit 24. Changes to the staged address have no effect on tbl_base or tbl_entries until the next such write.
- R6: Command bit 25 acts only when it differs from the value in the previous command write. A 0-to-1 change sets remap_en and a 1-to-0 change clears it.
- R7: At 0x0B8 the table address accepts a 4-byte write (low half only) or an 8-byte write (whole register). At 0x0BC it accepts only 4-byte writes to the high half, and an 8-byte write there is ignored.
- R8: The extended capability register at 0x010 reads 0x00F0000A: bit 3 is interrupt remapping, bit 1 is queued invalidation and bits 23:20 are the handle mask. Writes to it are ignored.
- R9: Global status bit 24 reports that a pointer has been latched, and it stays set. Bit 25 mirrors remap_en. All other status bits read zero.
- R10: Read data is zero when reg_rd is low, and also when the offset is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 12 | Byte offset |
| reg_size | input | 1 | Access size: 0 = 4 bytes, 1 = 8 bytes |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data (combinational) |
| tbl_base | output | HAW | Live table base, 4 KiB aligned |
| tbl_entries | output | 17 | Live number of table entries |
| remap_en | output | 1 | Remapping enable |

## Verification
The assertions assume that a write and a read never occur in the same cycle. They also assume that only a command write can move the live outputs, so any cycle without a command write must leave tbl_base, tbl_entries and remap_en unchanged. The bench drives every access from a negative-edge task that raises exactly one strobe for one cycle. It therefore never overlaps a write with a read or issues back-to-back strobes on the same edge. All size codes used in the stimulus are legal.

// File: rtl/irq_remap_regs.sv
module irq_remap_regs #(
  parameter int HAW = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [11:0]      reg_addr,
  input  logic             reg_size,
  input  logic [63:0]      reg_wdata,
  output logic [63:0]      reg_rdata,
  output logic [HAW-1:0]   tbl_base,
  output logic [16:0]      tbl_entries,
  output logic             remap_en
);
  localparam logic [11:0] OFS_XCAP  = 12'h010;
  localparam logic [11:0] OFS_CMD   = 12'h018;
  localparam logic [11:0] OFS_STS   = 12'h01C;
  localparam logic [11:0] OFS_TA_LO = 12'h0B8;
  localparam logic [11:0] OFS_TA_HI = 12'h0BC;
  localparam logic [63:0] TA_MASK   = 64'hFFFF_FFFF_FFFF_F00F;
  localparam logic [63:0] XCAP_VAL  = 64'h0000_0000_00F0_000A;
  localparam int          CMD_TP    = 24;
  localparam int          CMD_EN    = 25;
  localparam int          NW        = 17;

  logic [63:0]     ta_q;
  logic [HAW-13:0] base_q;
  logic [3:0]      sz_q;
  logic            tp_q, en_q, cmd_en_q;

  wire wr_lo  = reg_wr && (reg_addr == OFS_TA_LO);
  wire wr_hi  = reg_wr && (reg_addr == OFS_TA_HI) && !reg_size;
  wire wr_cmd = reg_wr && (reg_addr == OFS_CMD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ta_q     <= '0;
      base_q   <= '0;
      sz_q     <= '0;
      tp_q     <= 1'b0;
      en_q     <= 1'b0;
      cmd_en_q <= 1'b0;
    end else begin
      if (wr_lo) begin
        if (reg_size) ta_q <= reg_wdata & TA_MASK;
        else          ta_q[31:0] <= reg_wdata[31:0] & TA_MASK[31:0];
      end
      if (wr_hi) ta_q[63:32] <= reg_wdata[31:0] & TA_MASK[63:32];
      if (wr_cmd) begin
        cmd_en_q <= reg_wdata[CMD_EN];
        if (reg_wdata[CMD_TP]) begin
          base_q <= ta_q[HAW-1:12];
          sz_q   <= ta_q[3:0];
          tp_q   <= 1'b1;
        end
        if (reg_wdata[CMD_EN] != cmd_en_q) en_q <= reg_wdata[CMD_EN];
      end
    end
  end

  assign tbl_base    = {base_q, 12'h000};
  assign tbl_entries = tp_q ? (NW'(2) << sz_q) : '0;
  assign remap_en    = en_q;

  logic [31:0] sts;
  always_comb begin
    sts = '0;
    sts[CMD_TP] = tp_q;
    sts[CMD_EN] = en_q;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        OFS_XCAP:  reg_rdata = reg_size ? XCAP_VAL : {32'h0, XCAP_VAL[31:0]};
        OFS_STS:   reg_rdata = {32'h0, sts};
        OFS_TA_LO: reg_rdata = reg_size ? ta_q : {32'h0, ta_q[31:0]};
        OFS_TA_HI: reg_rdata = {32'h0, ta_q[63:32]};
        default:   reg_rdata = '0;
      endcase
    end
  end
endmodule

module irq_remap_regs_chk #(
  parameter int HAW = 48
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic           reg_rd,
  input logic [11:0]    reg_addr,
  input logic           reg_size,
  input logic [63:0]    reg_wdata,
  input logic [63:0]    reg_rdata,
  input logic [HAW-1:0] tbl_base,
  input logic [16:0]    tbl_entries,
  input logic           remap_en
);
  wire cmd_we = reg_wr && (reg_addr == 12'h018);

  assert_live_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> ($stable(tbl_base) && $stable(tbl_entries)));

  assert_latch_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && reg_wdata[24]) |=> (tbl_entries != 17'd0));

  assert_entries_pow2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tbl_entries) && !tbl_entries[0]);

  assert_en_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> $stable(remap_en));

  assert_en_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> (remap_en == $past(reg_wdata[25])));

  assert_xcap_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 12'h010) |-> (reg_rdata[31:0] == 32'h00F0_000A));

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |-> (reg_rdata == 64'h0));

  assert_base_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_base[11:0] == 12'h000);
endmodule

bind irq_remap_regs irq_remap_regs_chk #(.HAW(HAW)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .tbl_base(tbl_base), .tbl_entries(tbl_entries),
  .remap_en(remap_en)
);

// File: tb/irq_remap_regs_tb.sv
module irq_remap_regs_tb_top;
  localparam int HAW = 48;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           reg_wr = 1'b0, reg_rd = 1'b0, reg_size = 1'b0;
  logic [11:0]    reg_addr = '0;
  logic [63:0]    reg_wdata = '0;
  logic [63:0]    reg_rdata;
  logic [HAW-1:0] tbl_base;
  logic [16:0]    tbl_entries;
  logic           remap_en;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  irq_remap_regs #(.HAW(HAW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tbl_base(tbl_base), .tbl_entries(tbl_entries),
    .remap_en(remap_en)
  );

  task automatic wr(input logic [11:0] a, input logic sz, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_size = sz; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic sz, input logic [63:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    reg_rd = 1'b1; reg_addr = a; reg_size = sz;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] e);
    n_chk++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, e);
    end
  endtask

  task automatic ports(input string tag, input logic [63:0] b, input logic [16:0] n, input logic en);
    @(negedge clk);
    chk({tag, " base"}, 64'(tbl_base), b);
    chk({tag, " entries"}, 64'(tbl_entries), 64'(n));
    chk({tag, " enable"}, 64'(remap_en), 64'(en));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (reg_rd && exp_q.size() > 0) chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    ports("R1 reset", 64'h0, 17'd0, 1'b0);
    rd(12'h0B8, 1'b1, 64'h0, "R1 table address after reset");
    rd(12'h01C, 1'b0, 64'h0, "R1 status after reset");
    rd(12'h010, 1'b0, 64'h00F0_000A, "R8 capability");
    wr(12'h010, 1'b1, 64'h0);
    rd(12'h010, 1'b1, 64'h00F0_000A, "R8 capability after write");
    wr(12'h0B8, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(12'h0B8, 1'b1, 64'hFFFF_FFFF_FFFF_F00F, "R2 write mask");
    ports("R5 no latch yet", 64'h0, 17'd0, 1'b0);
    wr(12'h0B8, 1'b0, 64'hDEAD_0000_1234_5A05);
    wr(12'h0BC, 1'b0, 64'h0000_0000_0000_0ABC);
    rd(12'h0BC, 1'b0, 64'h0000_0ABC, "R7 high half 4-byte");
    rd(12'h0B8, 1'b0, 64'h1234_5005, "R7 low half 4-byte");
    wr(12'h0BC, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(12'h0B8, 1'b1, 64'h0000_0ABC_1234_5005, "R7 8-byte write to high half ignored");
    wr(12'h018, 1'b0, 64'h0100_0000);
    ports("R3 R4 R5 latch", 64'h0ABC_1234_5000, 17'd64, 1'b0);
    rd(12'h01C, 1'b0, 64'h0100_0000, "R9 pointer status");
    wr(12'h018, 1'b0, 64'h0300_0000);
    ports("R6 enable on", 64'h0ABC_1234_5000, 17'd64, 1'b1);
    rd(12'h01C, 1'b0, 64'h0300_0000, "R9 enable status");
    wr(12'h0B8, 1'b1, 64'hFFFF_0000_0000_3FFF);
    wr(12'h018, 1'b0, 64'h0200_0000);
    ports("R5 R6 no relatch, enable kept", 64'h0ABC_1234_5000, 17'd64, 1'b1);
    wr(12'h018, 1'b0, 64'h0300_0000);
    ports("R3 R4 max size and truncation", 64'h3000, 17'd65536, 1'b1);
    wr(12'h018, 1'b0, 64'h0100_0000);
    ports("R6 enable off", 64'h3000, 17'd65536, 1'b0);
    rd(12'h01C, 1'b0, 64'h0100_0000, "R9 status after disable");
    wr(12'h0B8, 1'b1, 64'h0000_0000_0000_5000);
    wr(12'h018, 1'b0, 64'h0100_0000);
    ports("R3 minimum size", 64'h5000, 17'd2, 1'b0);
    rd(12'h040, 1'b1, 64'h0, "R10 unmapped offset");
    reg_addr = 12'h0B8;
    @(negedge clk);
    chk("R10 idle read data", reg_rdata, 64'h0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule